// File: doc/BRIEF.md
# Noise-Shaping SAR Phase Sequencer

This block drives one conversion frame of a noise-shaping successive-approximation converter. A start request opens a sample window of fixed length, then the block walks eight bit decisions from MSB to LSB. Each decision fires the comparator and then waits for the comparator to report ready; the clock count between decisions therefore follows the comparator, not a fixed schedule. A watchdog stops a silent comparator from hanging the frame and records a 0 for that bit.

Sampling is on the top plate, so the MSB decision needs no capacitor move and only seven switched elements exist for eight result bits. Element j follows decision bit j+1. Each element has a pull-up and a pull-down control for both differential halves. Element 1 (decision bit 2) moves only one half, which halves its step. After the LSB decision the block issues three further phases in a fixed order: residue-DAC update, integrate, and integrator reset. It presents the result word with a one-cycle done strobe as the update phase opens. The phase outputs are mutually exclusive, so the analog switches they gate never overlap.

Top module: `ns_sar_seq`

## Requirements
- R1: A `startConv` pulse seen while every phase output is low raises `phSample` for exactly SAMPLE_CYC (default 2) cycles. `phConvert` follows at once.
- R2: Each conversion pulses `cmpTrig` exactly NBITS (8) times. Each decision is taken only when `cmpRdy` is high in a cycle after its trigger. The value of `cmpOut` at that moment becomes result bit NBITS-1 for the first decision, then bit NBITS-2, and so on down to bit 0.
- R3: `cmpRdy` or `cmpOut` activity outside a pending decision, such as during the sample phase, has no effect on the result.
- R4: If `cmpRdy` does not arrive within WDOG_LIM (default 12) wait cycles, the pending bit is forced to 0 and the next decision starts.
- R5: Switch element j (0..NBITS-2) reflects decision bit j+1, and decision bit 0 drives no element. For every element other than element 1: a 1 sets `swDnP[j]` and `swUpN[j]`, and a 0 sets `swUpP[j]` and `swDnN[j]`. Pull-up and pull-down of one half are never set together.
- R6: Element 1 moves one half only. A 1 sets only `swDnP[1]`, a 0 sets only `swDnN[1]`, and `swUpP[1]` and `swUpN[1]` stay 0.
- R7: All switch controls are 0 throughout the sample phase. They hold their final values through the update phase.
- R8: After the last decision, `phUpdate` lasts UPD_CYC (2) cycles, `phIntegrate` then lasts INT_CYC (3), and `phIntReset` then lasts RST_CYC (2). The block then returns to idle.
- R9: `convDone` is high for exactly one cycle per conversion, namely the first cycle of `phUpdate`. `resultWord` is valid in that cycle and holds until the next conversion completes.
- R10: At most one of the five phase outputs is high in any cycle. Phases occur only in the order idle, sample, convert, update, integrate, reset, idle.
- R11: `startConv` while a frame is in progress is ignored. The frame keeps its length and no second sample phase appears.
- R12: After reset, all phase outputs, `convDone`, `cmpTrig`, `resultWord` and all switch controls are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startConv | input | 1 | Request to begin a frame (used only when idle) |
| cmpRdy | input | 1 | Comparator has resolved |
| cmpOut | input | 1 | Comparator decision, 1 = positive side higher |
| cmpTrig | output | 1 | One-cycle pulse firing the comparator |
| phSample | output | 1 | Sample phase enable |
| phConvert | output | 1 | Bit-decision phase enable |
| phUpdate | output | 1 | Residue-DAC update phase enable |
| phIntegrate | output | 1 | Integrate phase enable |
| phIntReset | output | 1 | Integrator reset phase enable |
| convDone | output | 1 | One-cycle strobe, result valid |
| resultWord | output | 8 | Conversion result |
| swUpP | output | 7 | Positive-half pull-up per element |
| swDnP | output | 7 | Positive-half pull-down per element |
| swUpN | output | 7 | Negative-half pull-up per element |
| swDnN | output | 7 | Negative-half pull-down per element |

## Verification
The bench sweeps all 256 input codes with a comparator model whose response delay varies. It checks the word and every switch pattern, so a design that swaps the bit-to-element mapping or lets element 1 move both halves shows a wrong control bit. Silent-comparator cases with chosen bits withheld catch a watchdog that hangs or that latches a stale comparator value. A ready pulse injected during sampling would set the MSB on a design that listens outside a pending decision. A start issued mid-frame would show up as a second sample window or a stretched frame.

// File: rtl/ns_sar_pkg.sv
package ns_sar_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SAMP,
    ST_FIRE,
    ST_WAIT,
    ST_UPD,
    ST_INTG,
    ST_IRST
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic clear;   // new frame: wipe switches, reload bit pointer
    logic arm;     // decision fired: restart watchdog
    logic tick;    // waiting cycle: advance watchdog
    logic latch;   // take the pending decision
    logic useCmp;  // 1: take comparator value, 0: forced zero
  } seqStrobe_t;

endpackage

// File: rtl/ns_sar_ctrl.sv
module ns_sar_ctrl
  import ns_sar_pkg::*;
#(
  parameter int SAMPLE_CYC = 2,
  parameter int UPD_CYC    = 2,
  parameter int INT_CYC    = 3,
  parameter int RST_CYC    = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startConv,
  input  logic       cmpRdy,
  input  logic       lastBit,
  input  logic       wdogExpired,
  output seqStrobe_t strobe,
  output logic       cmpTrig,
  output logic       phSample,
  output logic       phConvert,
  output logic       phUpdate,
  output logic       phIntegrate,
  output logic       phIntReset,
  output logic       convDone
);

  localparam int MAX_A  = (SAMPLE_CYC > UPD_CYC) ? SAMPLE_CYC : UPD_CYC;
  localparam int MAX_B  = (INT_CYC > RST_CYC) ? INT_CYC : RST_CYC;
  localparam int MAX_CY = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNTW   = $clog2(MAX_CY + 1);

  seqState_t        state, stateNxt;
  logic [CNTW-1:0]  phaseCnt, phaseCntNxt;
  logic             takeDecision;

  assign takeDecision = (state == ST_WAIT) && (cmpRdy || wdogExpired);

  always_comb begin
    strobe        = '0;
    strobe.clear  = (state == ST_IDLE) && startConv;
    strobe.arm    = (state == ST_FIRE);
    strobe.tick   = (state == ST_WAIT) && !takeDecision;
    strobe.latch  = takeDecision;
    strobe.useCmp = cmpRdy;
  end

  always_comb begin
    stateNxt    = state;
    phaseCntNxt = phaseCnt + CNTW'(1);
    unique case (state)
      ST_IDLE: begin
        phaseCntNxt = '0;
        if (startConv) stateNxt = ST_SAMP;
      end
      ST_SAMP: begin
        if (phaseCnt == CNTW'(SAMPLE_CYC - 1)) begin
          stateNxt    = ST_FIRE;
          phaseCntNxt = '0;
        end
      end
      ST_FIRE: begin
        stateNxt    = ST_WAIT;
        phaseCntNxt = '0;
      end
      ST_WAIT: begin
        phaseCntNxt = '0;
        if (takeDecision) stateNxt = lastBit ? ST_UPD : ST_FIRE;
      end
      ST_UPD: begin
        if (phaseCnt == CNTW'(UPD_CYC - 1)) begin
          stateNxt    = ST_INTG;
          phaseCntNxt = '0;
        end
      end
      ST_INTG: begin
        if (phaseCnt == CNTW'(INT_CYC - 1)) begin
          stateNxt    = ST_IRST;
          phaseCntNxt = '0;
        end
      end
      ST_IRST: begin
        if (phaseCnt == CNTW'(RST_CYC - 1)) begin
          stateNxt    = ST_IDLE;
          phaseCntNxt = '0;
        end
      end
      default: begin
        stateNxt    = ST_IDLE;
        phaseCntNxt = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
    end else begin
      state    <= stateNxt;
      phaseCnt <= phaseCntNxt;
    end
  end

  assign phSample    = (state == ST_SAMP);
  assign phConvert   = (state == ST_FIRE) || (state == ST_WAIT);
  assign phUpdate    = (state == ST_UPD);
  assign phIntegrate = (state == ST_INTG);
  assign phIntReset  = (state == ST_IRST);
  assign cmpTrig     = (state == ST_FIRE);
  assign convDone    = (state == ST_UPD) && (phaseCnt == '0);

  // R10: phase enables never overlap
  a_r10_phase_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({phSample, phConvert, phUpdate, phIntegrate, phIntReset}));

  // R9: done is a single-cycle strobe
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    convDone |=> !convDone);

  // R8: update follows conversion, integrate follows update, reset follows integrate
  a_r8_update_after_convert: assert property (@(posedge clk) disable iff (!rstN)
    $fell(phConvert) |-> phUpdate);
  a_r8_integrate_after_update: assert property (@(posedge clk) disable iff (!rstN)
    $fell(phUpdate) |-> phIntegrate);
  a_r8_reset_after_integrate: assert property (@(posedge clk) disable iff (!rstN)
    $fell(phIntegrate) |-> phIntReset);

  // R11: no return to sampling from inside a conversion
  a_r11_no_resample: assert property (@(posedge clk) disable iff (!rstN)
    phConvert |=> !phSample);

endmodule

// File: rtl/ns_sar_datapath.sv
module ns_sar_datapath
  import ns_sar_pkg::*;
#(
  parameter int NBITS    = 8,
  parameter int HALF_BIT = 2,
  parameter int WDOG_LIM = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic             cmpOut,
  output logic             lastBit,
  output logic             wdogExpired,
  output logic [NBITS-1:0] resultWord,
  output logic [NBITS-2:0] swUpP,
  output logic [NBITS-2:0] swDnP,
  output logic [NBITS-2:0] swUpN,
  output logic [NBITS-2:0] swDnN
);

  localparam int IDXW    = $clog2(NBITS);
  localparam int WDW     = $clog2(WDOG_LIM + 1);
  localparam int NEL     = NBITS - 1;
  localparam int HALF_EL = HALF_BIT - 1;

  logic [IDXW-1:0]  bitIdx;
  logic [NBITS-1:0] workWord;
  logic [WDW-1:0]   wdogCnt;
  logic             decBit;

  assign decBit      = strobe.useCmp ? cmpOut : 1'b0;
  assign lastBit     = (bitIdx == '0);
  assign wdogExpired = (wdogCnt == WDW'(WDOG_LIM - 1));

  // Bit pointer and working word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitIdx   <= IDXW'(NBITS - 1);
      workWord <= '0;
    end else if (strobe.clear) begin
      bitIdx   <= IDXW'(NBITS - 1);
      workWord <= '0;
    end else if (strobe.latch) begin
      workWord[bitIdx] <= decBit;
      if (!lastBit) bitIdx <= bitIdx - IDXW'(1);
    end
  end

  // Final word register, loaded by the LSB decision
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultWord <= '0;
    end else if (strobe.latch && lastBit) begin
      resultWord <= {workWord[NBITS-1:1], decBit};
    end
  end

  // Decision watchdog
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdogCnt <= '0;
    end else if (strobe.arm || strobe.clear) begin
      wdogCnt <= '0;
    end else if (strobe.tick && !wdogExpired) begin
      wdogCnt <= wdogCnt + WDW'(1);
    end
  end

  // Switched elements: element j follows decision bit j+1
  for (genvar j = 0; j < NEL; j++) begin : g_elem
    localparam bit ONE_SIDED = (j == HALF_EL);
    logic hit;
    assign hit = strobe.latch && (bitIdx == IDXW'(j + 1));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        swUpP[j] <= 1'b0;
        swDnP[j] <= 1'b0;
        swUpN[j] <= 1'b0;
        swDnN[j] <= 1'b0;
      end else if (strobe.clear) begin
        swUpP[j] <= 1'b0;
        swDnP[j] <= 1'b0;
        swUpN[j] <= 1'b0;
        swDnN[j] <= 1'b0;
      end else if (hit) begin
        swDnP[j] <= decBit;
        swDnN[j] <= !decBit;
        if (ONE_SIDED) begin
          swUpP[j] <= 1'b0;
          swUpN[j] <= 1'b0;
        end else begin
          swUpP[j] <= !decBit;
          swUpN[j] <= decBit;
        end
      end
    end
  end

  // R5: a half never gets pull-up and pull-down together
  a_r5_no_short: assert property (@(posedge clk) disable iff (!rstN)
    ((swUpP & swDnP) | (swUpN & swDnN)) == '0);

  // R6: the one-sided element never pulls up
  a_r6_half_one_side: assert property (@(posedge clk) disable iff (!rstN)
    !swUpP[HALF_EL] && !swUpN[HALF_EL]);

  // R4: watchdog never runs past its limit
  a_r4_wdog_bound: assert property (@(posedge clk) disable iff (!rstN)
    wdogCnt < WDW'(WDOG_LIM));

  // R2: a decision consumes one bit position, MSB first
  a_r2_pointer_steps: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.latch && !lastBit && !strobe.clear) |=> (bitIdx == $past(bitIdx) - IDXW'(1)));

endmodule

// File: rtl/ns_sar_seq.sv
module ns_sar_seq
  import ns_sar_pkg::*;
#(
  parameter int NBITS      = 8,
  parameter int HALF_BIT   = 2,
  parameter int WDOG_LIM   = 12,
  parameter int SAMPLE_CYC = 2,
  parameter int UPD_CYC    = 2,
  parameter int INT_CYC    = 3,
  parameter int RST_CYC    = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startConv,
  input  logic             cmpRdy,
  input  logic             cmpOut,
  output logic             cmpTrig,
  output logic             phSample,
  output logic             phConvert,
  output logic             phUpdate,
  output logic             phIntegrate,
  output logic             phIntReset,
  output logic             convDone,
  output logic [NBITS-1:0] resultWord,
  output logic [NBITS-2:0] swUpP,
  output logic [NBITS-2:0] swDnP,
  output logic [NBITS-2:0] swUpN,
  output logic [NBITS-2:0] swDnN
);

  seqStrobe_t strobe;
  logic       lastBit;
  logic       wdogExpired;

  ns_sar_ctrl #(
    .SAMPLE_CYC(SAMPLE_CYC),
    .UPD_CYC   (UPD_CYC),
    .INT_CYC   (INT_CYC),
    .RST_CYC   (RST_CYC)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startConv  (startConv),
    .cmpRdy     (cmpRdy),
    .lastBit    (lastBit),
    .wdogExpired(wdogExpired),
    .strobe     (strobe),
    .cmpTrig    (cmpTrig),
    .phSample   (phSample),
    .phConvert  (phConvert),
    .phUpdate   (phUpdate),
    .phIntegrate(phIntegrate),
    .phIntReset (phIntReset),
    .convDone   (convDone)
  );

  ns_sar_datapath #(
    .NBITS   (NBITS),
    .HALF_BIT(HALF_BIT),
    .WDOG_LIM(WDOG_LIM)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cmpOut     (cmpOut),
    .lastBit    (lastBit),
    .wdogExpired(wdogExpired),
    .resultWord (resultWord),
    .swUpP      (swUpP),
    .swDnP      (swDnP),
    .swUpN      (swUpN),
    .swDnN      (swDnN)
  );

  // R7: switches are idle while sampling
  a_r7_switches_clear_in_sample: assert property (@(posedge clk) disable iff (!rstN)
    phSample |-> ((swUpP | swDnP | swUpN | swDnN) == '0));

endmodule

// File: tb/tb_ns_sar_seq.sv
module tb_ns_sar_seq;

  localparam int CLK_PERIOD = 10;
  localparam int NB         = 8;
  localparam int SAMP_N     = 2;
  localparam int UPD_N      = 2;
  localparam int INT_N      = 3;
  localparam int RST_N      = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startConv = 1'b0;
  logic cmpRdy, cmpOut;
  logic modelRdy = 1'b0, modelOut = 1'b0;
  logic strayRdy = 1'b0, strayOut = 1'b0;
  logic cmpTrig, phSample, phConvert, phUpdate, phIntegrate, phIntReset, convDone;
  logic [NB-1:0] resultWord;
  logic [NB-2:0] swUpP, swDnP, swUpN, swDnN;

  assign cmpRdy = modelRdy | strayRdy;
  assign cmpOut = modelOut | strayOut;

  int compared = 0;
  int mismatched = 0;

  // comparator model settings
  logic [NB-1:0] code = '0;
  logic [NB-1:0] skipMask = '0;
  int lat = 1;
  int trigCnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ns_sar_seq dut (
    .clk(clk), .rstN(rstN), .startConv(startConv), .cmpRdy(cmpRdy), .cmpOut(cmpOut),
    .cmpTrig(cmpTrig), .phSample(phSample), .phConvert(phConvert), .phUpdate(phUpdate),
    .phIntegrate(phIntegrate), .phIntReset(phIntReset), .convDone(convDone),
    .resultWord(resultWord), .swUpP(swUpP), .swDnP(swDnP), .swUpN(swUpN), .swDnN(swDnN)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Behavioural comparator: a perfect decision on the input code
  initial begin
    int bitPos;
    forever begin
      @(negedge clk);
      while (cmpTrig) begin
        bitPos = NB - 1 - trigCnt;
        trigCnt++;
        if (bitPos < 0 || skipMask[bitPos]) begin
          @(negedge clk);
        end else begin
          repeat (lat) @(negedge clk);
          modelRdy = 1'b1;
          modelOut = code[bitPos];
          @(negedge clk);
          modelRdy = 1'b0;
          modelOut = 1'b0;
        end
      end
    end
  end

  function automatic int phaseCode();
    int n;
    n = int'(phSample) + int'(phConvert) + int'(phUpdate) + int'(phIntegrate) + int'(phIntReset);
    if (n > 1) return 6;
    if (phSample) return 1;
    if (phConvert) return 2;
    if (phUpdate) return 3;
    if (phIntegrate) return 4;
    if (phIntReset) return 5;
    return 0;
  endfunction

  task automatic checkSwitches(input logic [NB-1:0] e, input string tag);
    logic [NB-2:0] eUpP, eDnP, eUpN, eDnN;
    for (int j = 0; j < NB - 1; j++) begin
      eDnP[j] = e[j+1];
      eDnN[j] = !e[j+1];
      if (j == 1) begin
        eUpP[j] = 1'b0;
        eUpN[j] = 1'b0;
      end else begin
        eUpP[j] = !e[j+1];
        eUpN[j] = e[j+1];
      end
    end
    chk({swUpP, swDnP, swUpN, swDnN} == {eUpP, eDnP, eUpN, eDnN}, tag,
        int'({swUpP, swDnP, swUpN, swDnN}), int'({eUpP, eDnP, eUpN, eDnN}));
  endtask

  task automatic runConv(input logic [NB-1:0] c, input int l, input logic [NB-1:0] sk,
                         input bit straySample, input bit busyStart);
    logic [NB-1:0] expWord;
    int sampN, convN, updN, intN, rstN_c, doneN, badTrans, cur, prev, cyc, swDirty;
    bit seenRst;
    expWord = c & ~sk;
    code = c; lat = l; skipMask = sk; trigCnt = 0;
    sampN = 0; convN = 0; updN = 0; intN = 0; rstN_c = 0; doneN = 0;
    badTrans = 0; swDirty = 0; seenRst = 0; prev = 0; cyc = 0;
    @(negedge clk);
    startConv = 1'b1;
    @(negedge clk);
    startConv = 1'b0;
    while (!(seenRst && phaseCode() == 0) && cyc < 1000) begin
      cur = phaseCode();
      strayRdy = 1'b0; strayOut = 1'b0;
      startConv = 1'b0;
      if (!(cur == prev || cur == prev + 1 || (prev == 5 && cur == 0))) badTrans++;
      case (cur)
        1: sampN++;
        2: convN++;
        3: updN++;
        4: intN++;
        5: begin rstN_c++; seenRst = 1; end
        default: ;
      endcase
      if (cur == 1 && (swUpP | swDnP | swUpN | swDnN) != '0) swDirty++;
      if (convDone) begin
        doneN++;
        // R9 done coincides with first update cycle; R2/R4 result value
        chk(cur == 3 && updN == 1, "R9 done in first update cycle", updN, 1);
        chk(resultWord == expWord, (sk != 0) ? "R4 watchdog result" : "R2 result word",
            resultWord, expWord);
        checkSwitches(expWord, (expWord[2] !== 1'bx) ? "R5/R6 switch pattern" : "R5");
      end
      if (cur == 3 && updN == UPD_N) checkSwitches(expWord, "R7 switches held in update");
      if (straySample && cur == 1) begin strayRdy = 1'b1; strayOut = 1'b1; end
      if (busyStart && cyc == 6) startConv = 1'b1;
      prev = cur;
      @(negedge clk);
      cyc++;
    end
    strayRdy = 1'b0; strayOut = 1'b0; startConv = 1'b0;
    chk(cyc < 1000, "R8 frame completes", cyc, 0);
    chk(sampN == SAMP_N, "R1 sample length", sampN, SAMP_N);
    chk(convN >= NB * 2, "R2 convert phase present", convN, NB * 2);
    chk(trigCnt == NB, "R2 comparator fired eight times", trigCnt, NB);
    chk(updN == UPD_N, "R8 update length", updN, UPD_N);
    chk(intN == INT_N, "R8 integrate length", intN, INT_N);
    chk(rstN_c == RST_N, "R8 reset length", rstN_c, RST_N);
    chk(badTrans == 0, "R10 phase order/exclusive", badTrans, 0);
    chk(doneN == 1, "R9 single done", doneN, 1);
    chk(swDirty == 0, "R7 switches clear in sample", swDirty, 0);
    chk(resultWord == expWord, "R9 result held after frame", resultWord, expWord);
    if (straySample)
      chk(resultWord == expWord, "R3 stray ready ignored", resultWord, expWord);
    if (busyStart) begin
      repeat (3) @(negedge clk);
      chk(phaseCode() == 0, "R11 busy start ignored", phaseCode(), 0);
    end
  endtask

  // Run watchdog
  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk({phSample, phConvert, phUpdate, phIntegrate, phIntReset, convDone, cmpTrig} == '0,
        "R12 phases idle in reset", int'({phSample, phConvert, phUpdate, phIntegrate, phIntReset}), 0);
    chk(resultWord == '0, "R12 result zero", resultWord, 0);
    chk((swUpP | swDnP | swUpN | swDnN) == '0, "R12 switches zero",
        int'(swUpP | swDnP | swUpN | swDnN), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(phaseCode() == 0, "R12 idle after reset", phaseCode(), 0);

    // Exhaustive code sweep, varying comparator latency
    for (int c = 0; c < 256; c++) runConv(8'(c), 1 + (c % 3), 8'h00, 1'b0, 1'b0);

    // R4 silent comparator on chosen bits
    runConv(8'hFF, 1, 8'h81, 1'b0, 1'b0);
    runConv(8'h24, 2, 8'h04, 1'b0, 1'b0);
    runConv(8'hFF, 1, 8'hFF, 1'b0, 1'b0);
    runConv(8'h5A, 3, 8'h42, 1'b0, 1'b0);

    // R3 stray ready during sampling
    runConv(8'h00, 1, 8'h00, 1'b1, 1'b0);
    runConv(8'h3C, 2, 8'h00, 1'b1, 1'b0);

    // R11 start while busy
    runConv(8'hA5, 1, 8'h00, 1'b0, 1'b1);
    runConv(8'h96, 2, 8'h00, 1'b0, 1'b0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule